// File: doc/BRIEF.md
# Daisy-Chained Codec Channel Serial Port

This block is the serial port of one channel in a chain of codec channels that share a single link to a host processor. Each word is 16 bits long. A one-clock input frame pulse marks its start, and its bits arrive most significant first on the 16 clocks that follow. The block sends words downstream in the same format, on its own output frame pulse and data line. On every sampling event it loads the channel's current sample word and sends it on. Whatever comes in from upstream is either kept by this channel or passed along, so the words of all channels travel through one chain.

Routing depends on the mode. In program mode a word is a control word when its flag bit is set. A control word with a zero address belongs to this channel and is written into one of three small configuration registers. Any other control word is passed on with its address lowered by one. In data mode the channel counts the words it receives. The word whose count reaches the programmed chain length is latched as the channel's converter word, and the counter starts again. The configuration fields only drive output pins.

Top module: `chain_port`

## Requirements
- R1: After reset the channel is in program mode. All configuration fields, the converter word and the frame counter are zero, and `fsOut` and `sdOut` are low.
- R2: An input word is framed by `fsIn` high for one clock. Its 16 bits, MSB first, are sampled on the 16 rising edges after the edge that sampled `fsIn`. An output word is `fsOut` high for one cycle, then 16 bits MSB first on `sdOut`, one per cycle. A passed-on word raises `fsOut` 17 clocks after the input frame pulse was sampled.
- R3: A `sampleEvent` pulse loads `sampleWord` and raises `fsOut` in the cycle after the edge that sampled the pulse, followed by that word.
- R4: In program mode, a word with bit 15 = 1 and address bits 13:11 = 0 is written into a register chosen by bits 10:8, using the data in bits 7:0, and it is not passed on. Select 0 sets the chain length from data bits 2:0 and the mode from data bit 7. Select 1 sets the clock divider from bits 2:0, the serial-clock rate from bits 4:3 and the sample rate from bits 6:5. Select 2 sets the converter power bits: bit 0 for the ADC, bit 1 for the DAC, bit 2 for the reference.
- R5: A control word addressed to this channel with a select of 3 to 7 changes no register and is not passed on.
- R6: In program mode, a control word with a nonzero address is passed on with bits 13:11 lowered by one and every other bit unchanged. No register changes.
- R7: In program mode, a word with bit 15 = 0 is passed on unchanged.
- R8: Writing mode bit 1 through select 0 puts the channel in data mode, shown on `dataMode`. From then on, configuration registers are no longer written.
- R9: In data mode, each received word raises the frame count by one. A word that makes the count equal the chain length is latched onto `dacWord` and not passed on. Any other word is passed on unchanged, whatever its bit 15.
- R10: After a latch the frame count returns to zero, so the pattern repeats every chain-length words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| sdIn | input | 1 | Serial data from upstream |
| fsIn | input | 1 | Input frame pulse |
| sampleEvent | input | 1 | Sampling event strobe |
| sampleWord | input | 16 | Sample word sent at a sampling event |
| sdOut | output | 1 | Serial data downstream |
| fsOut | output | 1 | Output frame pulse |
| dacWord | output | 16 | Latched converter word |
| dataMode | output | 1 | 1 in data mode, 0 in program mode |
| cascLen | output | 3 | Chain length field |
| clkDiv | output | 3 | Clock divider selection |
| sclkRate | output | 2 | Serial clock rate selection |
| sampRate | output | 2 | Sample rate selection |
| pwrAdc | output | 1 | ADC power-up |
| pwrDac | output | 1 | DAC power-up |
| pwrRef | output | 1 | Reference power-up |

## Verification
The bench drives a control word whose flag bit is set and whose address is nonzero. A design that wrote it locally, or passed it on without lowering the address, would corrupt the downstream channels. It also sends an addressed word with an unused select. A design that decoded only some of the select bits would silently overwrite a register. A data-mode word whose bit 15 is set checks that the mode change really switches off control decoding. Two full data cycles with a chain length of two check that the frame counter wraps. A counter that was not cleared after a latch would deliver the second converter word to the wrong channel. The output frame timing is compared against a fixed latency, so an extra or a missing register stage shows up.

// File: rtl/chain_port_pkg.sv
package chain_port_pkg;
  localparam int WORD_W   = 16;
  localparam int BIT_W    = $clog2(WORD_W);
  localparam int ADDR_W   = 3;
  localparam int SEL_W    = 3;
  localparam int DATA_W   = 8;
  localparam int CASC_W   = 3;
  localparam int FLAG_POS = WORD_W - 1;
  localparam int ADDR_LSB = 11;
  localparam int SEL_LSB  = 8;
  localparam int MODE_POS = 7;

  typedef struct packed {
    logic shiftIn;
    logic loadSample;
    logic loadFwd;
    logic fwdDec;
    logic shiftOut;
    logic writeReg;
    logic latchDac;
  } strobe_t;
endpackage

// File: rtl/chain_port_ctrl.sv
module chain_port_ctrl
  import chain_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fsIn,
  input  logic              sampleEvent,
  input  logic              rxFlag,
  input  logic [ADDR_W-1:0] rxAddr,
  input  logic              dataMode,
  input  logic [CASC_W-1:0] cascLen,
  output strobe_t           stb,
  output logic              fsOut,
  output logic              txOn
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic              rxOn;
  logic [BIT_W-1:0]  rxBits;
  logic              rxDone;
  logic              txFs;
  logic [BIT_W-1:0]  txBits;
  logic [CASC_W-1:0] frameCnt;
  logic [CASC_W-1:0] nextCnt;
  logic              txStart;

  assign nextCnt = frameCnt + CASC_W'(1);
  assign txStart = stb.loadSample | stb.loadFwd;
  assign fsOut   = txFs;

  always_comb begin
    stb = '0;
    stb.shiftIn    = rxOn & ~fsIn;
    stb.loadSample = sampleEvent;
    if (rxDone) begin
      if (!dataMode) begin
        if (rxFlag && rxAddr == '0) begin
          stb.writeReg = 1'b1;
        end else begin
          stb.loadFwd = 1'b1;
          stb.fwdDec  = rxFlag;
        end
      end else if (nextCnt == cascLen) begin
        stb.latchDac = 1'b1;
      end else begin
        stb.loadFwd = 1'b1;
      end
    end
    stb.shiftOut = txOn && (txBits != LAST_BIT) && !txStart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxOn     <= 1'b0;
      rxBits   <= '0;
      rxDone   <= 1'b0;
      txFs     <= 1'b0;
      txOn     <= 1'b0;
      txBits   <= '0;
      frameCnt <= '0;
    end else begin
      rxDone <= 1'b0;
      if (fsIn) begin
        rxOn   <= 1'b1;
        rxBits <= '0;
      end else if (rxOn) begin
        rxBits <= rxBits + BIT_W'(1);
        if (rxBits == LAST_BIT) begin
          rxOn   <= 1'b0;
          rxDone <= 1'b1;
        end
      end

      if (txStart) begin
        txFs   <= 1'b1;
        txOn   <= 1'b0;
        txBits <= '0;
      end else if (txFs) begin
        txFs <= 1'b0;
        txOn <= 1'b1;
      end else if (txOn) begin
        if (txBits == LAST_BIT) txOn <= 1'b0;
        else                    txBits <= txBits + BIT_W'(1);
      end

      if (stb.latchDac)            frameCnt <= '0;
      else if (rxDone && dataMode) frameCnt <= nextCnt;
    end
  end

  // R6 / R7: a word is only passed on once it has been fully received
  a_r6_fwd_after_word: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadFwd |-> rxDone);

  // R4 / R9: each received word leads to at most one action
  a_r4_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.writeReg, stb.latchDac, stb.loadFwd}));

  // R10: the frame count stays below the chain length in data mode
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    (dataMode && cascLen != '0) |-> (frameCnt < cascLen));

  // R2: the frame pulse and the data bits never overlap
  a_r2_fs_before_bits: assert property (@(posedge clk) disable iff (!rstN)
    txOn |-> !txFs);

  // R2: a word's bits begin on the cycle after its frame pulse
  a_r2_bits_follow_fs: assert property (@(posedge clk) disable iff (!rstN)
    (txFs && !txStart) |=> txOn);
endmodule

// File: rtl/chain_port_dp.sv
module chain_port_dp
  import chain_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdIn,
  input  strobe_t           stb,
  input  logic              txOn,
  input  logic [WORD_W-1:0] sampleWord,
  output logic              rxFlag,
  output logic [ADDR_W-1:0] rxAddr,
  output logic              sdOut,
  output logic [WORD_W-1:0] dacWord,
  output logic              dataMode,
  output logic [CASC_W-1:0] cascLen,
  output logic [6:0]        regB,
  output logic [2:0]        regC
);
  logic [WORD_W-1:0] rxShift;
  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] fwdWord;
  logic [SEL_W-1:0]  sel;
  logic [DATA_W-1:0] data;

  assign rxFlag = rxShift[FLAG_POS];
  assign rxAddr = rxShift[ADDR_LSB +: ADDR_W];
  assign sel    = rxShift[SEL_LSB +: SEL_W];
  assign data   = rxShift[DATA_W-1:0];
  assign sdOut  = txOn & txShift[WORD_W-1];

  always_comb begin
    fwdWord = rxShift;
    if (stb.fwdDec) fwdWord[ADDR_LSB +: ADDR_W] = rxAddr - ADDR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift  <= '0;
      txShift  <= '0;
      dacWord  <= '0;
      dataMode <= 1'b0;
      cascLen  <= '0;
      regB     <= '0;
      regC     <= '0;
    end else begin
      if (stb.shiftIn) rxShift <= {rxShift[WORD_W-2:0], sdIn};

      if (stb.loadSample)    txShift <= sampleWord;
      else if (stb.loadFwd)  txShift <= fwdWord;
      else if (stb.shiftOut) txShift <= {txShift[WORD_W-2:0], 1'b0};

      if (stb.latchDac) dacWord <= rxShift;

      if (stb.writeReg) begin
        case (sel)
          SEL_W'(0): begin
            cascLen  <= data[CASC_W-1:0];
            dataMode <= data[MODE_POS];
          end
          SEL_W'(1): regB <= data[6:0];
          SEL_W'(2): regC <= data[2:0];
          default: ;
        endcase
      end
    end
  end

  // R8: no configuration write once in data mode
  a_r8_regs_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (dataMode && $past(dataMode)) |-> ($stable(regB) && $stable(regC) && $stable(cascLen)));

  // R9: the converter word only changes in data mode
  a_r9_dac_data_only: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacWord) |-> $past(dataMode));
endmodule

// File: rtl/chain_port.sv
module chain_port
  import chain_port_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sdIn,
  input  logic        fsIn,
  input  logic        sampleEvent,
  input  logic [15:0] sampleWord,
  output logic        sdOut,
  output logic        fsOut,
  output logic [15:0] dacWord,
  output logic        dataMode,
  output logic [2:0]  cascLen,
  output logic [2:0]  clkDiv,
  output logic [1:0]  sclkRate,
  output logic [1:0]  sampRate,
  output logic        pwrAdc,
  output logic        pwrDac,
  output logic        pwrRef
);
  strobe_t           stb;
  logic              txOn;
  logic              rxFlag;
  logic [ADDR_W-1:0] rxAddr;
  logic [6:0]        regB;
  logic [2:0]        regC;

  chain_port_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .fsIn(fsIn), .sampleEvent(sampleEvent),
    .rxFlag(rxFlag), .rxAddr(rxAddr), .dataMode(dataMode), .cascLen(cascLen),
    .stb(stb), .fsOut(fsOut), .txOn(txOn)
  );

  chain_port_dp uDp (
    .clk(clk), .rstN(rstN), .sdIn(sdIn), .stb(stb), .txOn(txOn),
    .sampleWord(sampleWord), .rxFlag(rxFlag), .rxAddr(rxAddr), .sdOut(sdOut),
    .dacWord(dacWord), .dataMode(dataMode), .cascLen(cascLen),
    .regB(regB), .regC(regC)
  );

  assign clkDiv   = regB[2:0];
  assign sclkRate = regB[4:3];
  assign sampRate = regB[6:5];
  assign pwrAdc   = regC[0];
  assign pwrDac   = regC[1];
  assign pwrRef   = regC[2];
endmodule

// File: tb/sim_chain_port.sv
module sim_chain_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sdIn = 1'b0;
  logic        fsIn = 1'b0;
  logic        sampleEvent = 1'b0;
  logic [15:0] sampleWord = '0;
  logic        sdOut, fsOut, dataMode, pwrAdc, pwrDac, pwrRef;
  logic [15:0] dacWord;
  logic [2:0]  cascLen, clkDiv;
  logic [1:0]  sclkRate, sampRate;

  int checks = 0;
  int errors = 0;
  int cycCnt = 0;
  bit finished = 0;

  logic [15:0] cap [0:31];
  int          capAt [0:31];
  int          capN = 0;
  bit          mOn = 0;
  int          mBits = 0;
  int          mFsAt = 0;
  logic [15:0] mWord = '0;

  chain_port u0 (
    .clk(clk), .rstN(rstN), .sdIn(sdIn), .fsIn(fsIn), .sampleEvent(sampleEvent),
    .sampleWord(sampleWord), .sdOut(sdOut), .fsOut(fsOut), .dacWord(dacWord),
    .dataMode(dataMode), .cascLen(cascLen), .clkDiv(clkDiv), .sclkRate(sclkRate),
    .sampRate(sampRate), .pwrAdc(pwrAdc), .pwrDac(pwrDac), .pwrRef(pwrRef)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cycCnt <= cycCnt + 1;

  // output word monitor, sampling on the falling edge
  always @(negedge clk) begin
    if (fsOut) begin
      mOn = 1; mBits = 0; mFsAt = cycCnt;
    end else if (mOn) begin
      mWord = {mWord[14:0], sdOut};
      mBits++;
      if (mBits == 16) begin
        if (capN < 32) begin
          cap[capN] = mWord; capAt[capN] = mFsAt; capN++;
        end
        mOn = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sendWord(input logic [15:0] w, output int at);
    @(negedge clk);
    fsIn = 1'b1; at = cycCnt;
    @(negedge clk);
    fsIn = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      sdIn = w[i];
      @(negedge clk);
    end
    sdIn = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic tReset();
    repeat (3) @(negedge clk);
    chk("R1 fsOut", fsOut, 0);
    chk("R1 sdOut", sdOut, 0);
    chk("R1 dataMode", dataMode, 0);
    chk("R1 fields", {cascLen, clkDiv, sclkRate, sampRate, pwrAdc, pwrDac, pwrRef}, 0);
    chk("R1 dacWord", dacWord, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {fsOut, sdOut}, 0);
  endtask

  task automatic tSample();
    int n0, at;
    n0 = capN;
    @(negedge clk);
    sampleWord = 16'hA5C3; sampleEvent = 1'b1; at = cycCnt;
    @(negedge clk);
    sampleEvent = 1'b0;
    settle();
    chk("R3 word count", capN, n0 + 1);
    chk("R3 sample word", cap[n0], 16'hA5C3);
    chk("R3 fs latency", capAt[n0] - at, 1);
  endtask

  task automatic tPassThrough();
    int n0, at;
    n0 = capN;
    sendWord(16'h1234, at);
    settle();
    chk("R7 word count", capN, n0 + 1);
    chk("R7 unchanged", cap[n0], 16'h1234);
    chk("R2 forward latency", capAt[n0] - at, 18);
  endtask

  task automatic tForwardDec();
    int n0, at;
    n0 = capN;
    sendWord(16'h9155, at);
    settle();
    chk("R6 word count", capN, n0 + 1);
    chk("R6 address lowered", cap[n0], 16'h8955);
    chk("R6 no register change", {cascLen, clkDiv, sclkRate, sampRate}, 0);
  endtask

  task automatic tWriteRegs();
    int n0, at;
    n0 = capN;
    sendWord(16'h815D, at);
    settle();
    chk("R4 clkDiv", clkDiv, 5);
    chk("R4 sclkRate", sclkRate, 3);
    chk("R4 sampRate", sampRate, 2);
    sendWord(16'h8207, at);
    settle();
    chk("R4 power bits", {pwrRef, pwrDac, pwrAdc}, 3'b111);
    chk("R4 not forwarded", capN, n0);
  endtask

  task automatic tBadSelect();
    int n0, at;
    n0 = capN;
    sendWord(16'h85FF, at);
    settle();
    chk("R5 fields untouched",
        {cascLen, dataMode, clkDiv, sclkRate, sampRate, pwrRef, pwrDac, pwrAdc},
        {3'd0, 1'b0, 3'd5, 2'd3, 2'd2, 3'b111});
    chk("R5 not forwarded", capN, n0);
  endtask

  task automatic tEnterData();
    int at;
    sendWord(16'h8082, at);
    settle();
    chk("R8 dataMode", dataMode, 1);
    chk("R8 cascLen", cascLen, 2);
  endtask

  task automatic tDataCycle();
    int n0, at;
    n0 = capN;
    sendWord(16'h8111, at);
    settle();
    chk("R9 first word forwarded", cap[n0], 16'h8111);
    chk("R9 dac not yet updated", dacWord, 0);
    chk("R8 flagged word not decoded", {clkDiv, pwrAdc}, {3'd5, 1'b1});
    sendWord(16'h4242, at);
    settle();
    chk("R9 dac latched", dacWord, 16'h4242);
    chk("R9 latched word kept", capN, n0 + 1);
    sendWord(16'h7777, at);
    settle();
    chk("R10 counter restarted, forward", cap[n0 + 1], 16'h7777);
    chk("R10 dac held", dacWord, 16'h4242);
    sendWord(16'h1357, at);
    settle();
    chk("R10 second latch", dacWord, 16'h1357);
    chk("R10 word count", capN, n0 + 2);
  endtask

  initial begin
    tReset();
    tSample();
    tPassThrough();
    tForwardDec();
    tWriteRegs();
    tBadSelect();
    tEnterData();
    tDataCycle();
    tSample();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule